// File: doc/BRIEF.md
# Configurable I/Q Sample Formatter

This block sits between a narrow parallel input port and a dual-channel converter datapath. Each accepted input beat carries part of an interleaved pair of 16-bit samples, one for I and one for Q. The block rebuilds both samples from these beats and presents them together on one output with a pair-valid strobe. Both outputs are always in twos complement.

Four plain configuration pins set how the beats are read:
- the bus width code, which picks byte assembly or nibble assembly;
- which sample of the pair comes first;
- whether the bits of every beat are mirrored;
- whether the words arrive as offset binary.

A start marker on the input tags the first beat of a pair, so the block can realign after an interrupted transfer.

Both streams use valid/ready. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. A pair transfers on an edge where `out_valid` and `out_ready` are both high. The output holds one pair. While that pair waits for `out_ready`, the output holds it unchanged and `in_ready` stays low. In the invalid width mode the block accepts every beat and discards it. This keeps the upstream side from stalling. The configuration pins are expected to stay fixed while a pair is being assembled.

Top module: `iq_word_builder`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0 and `in_ready` is 1.
- R2: Width codes 00 and 01 both select byte assembly. A pair is four accepted beats of `in_data[7:0]`, most significant byte first. The first 16-bit word is formed before the second. The pair appears with `out_valid` high one clock after the fourth beat is accepted.
- R3: Width code 10 selects nibble assembly. A pair is eight beats of `in_data[3:0]`, most significant nibble first. `in_data[7:4]` is ignored.
- R4: With `cfg_q_first`=0 the first word goes to `out_i` and the second to `out_q`. With `cfg_q_first`=1 the first word goes to `out_q` and the second to `out_i`.
- R5: With `cfg_bitrev`=1 each beat is mirrored before assembly. In byte mode pin bit k becomes bit 7-k. In nibble mode pin bit k becomes bit 3-k, for k from 0 to 3.
- R6: With `cfg_offset_bin`=1 bit 15 of each assembled sample is inverted. With 0 the samples pass through unchanged.
- R7: A beat accepted with `in_first`=1 is beat 0 of a new pair. Any partly assembled pair is dropped.
- R8: Width code 11 sets `cfg_err` to 1 and holds `in_ready` at 1. Every beat is discarded and no new pair is produced.
- R9: While `out_valid`=1 and `out_ready`=0, the output pair stays stable and `in_ready` is 0 (in any valid width mode).
- R10: `out_valid` rises only in the clock after a beat that completes a pair was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Bus width code: 00/01 byte, 10 nibble, 11 invalid |
| cfg_q_first | input | 1 | 1: Q word arrives first in each pair |
| cfg_bitrev | input | 1 | 1: mirror the bit order of each beat |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| cfg_err | output | 1 | Invalid width code selected |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Input beat; nibble mode uses bits 3:0 |
| in_first | input | 1 | Beat is the first of a pair |
| out_valid | output | 1 | Pair valid |
| out_ready | input | 1 | Downstream takes the pair |
| out_i | output | 16 | I sample, twos complement |
| out_q | output | 16 | Q sample, twos complement |

## Verification
The hardest case to reach from the ports is realigning on `in_first` after a partial pair has already left bits in the shift register. If the restart is wrong, those stale bits leak into the next pair. The stimulus sends three beats of a pair and abandons it. It then starts a full pair with the start marker set, in both byte and nibble mode, and checks that only the clean pair comes out. Back-pressure is exercised separately: the output is held blocked while a pair is waiting, and the bench checks that the next pair's beats stall and that the waiting data does not move.

// File: rtl/iqwb_pkg.sv
package iqwb_pkg;
  typedef enum logic [1:0] {WM_BYTE, WM_NIBBLE, WM_BAD} width_mode_e;

  function automatic width_mode_e decode_width(input logic [1:0] code);
    case (code)
      2'b10:   return WM_NIBBLE;
      2'b11:   return WM_BAD;
      default: return WM_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/iqwb_lane.sv
module iqwb_lane #(
  parameter int BUS_W = 8,
  parameter int NIB_W = 4
) (
  input  logic [BUS_W-1:0] raw,
  input  logic             nib_mode,
  input  logic             bitrev,
  output logic [BUS_W-1:0] lane
);
  logic [BUS_W-1:0] rev_full;
  logic [NIB_W-1:0] rev_nib;

  for (genvar k = 0; k < BUS_W; k++) begin : g_full
    assign rev_full[k] = raw[BUS_W-1-k];
  end
  for (genvar k = 0; k < NIB_W; k++) begin : g_nib
    assign rev_nib[k] = raw[NIB_W-1-k];
  end

  always_comb begin
    if (nib_mode)
      lane = {{(BUS_W-NIB_W){1'b0}}, (bitrev ? rev_nib : raw[NIB_W-1:0])};
    else
      lane = bitrev ? rev_full : raw;
  end
endmodule

// File: rtl/iqwb_assembler.sv
module iqwb_assembler #(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8,
  parameter int NIB_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  first,
  input  logic                  nib_mode,
  input  logic [BUS_W-1:0]      lane,
  output logic                  done,
  output logic [2*SAMPLE_W-1:0] pair
);
  localparam int PAIR_W     = 2 * SAMPLE_W;
  localparam int BYTE_BEATS = PAIR_W / BUS_W;
  localparam int NIB_BEATS  = PAIR_W / NIB_W;
  localparam int CNT_W      = $clog2(NIB_BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_BEATS - 1);
  localparam logic [CNT_W-1:0] LAST_NIB  = CNT_W'(NIB_BEATS - 1);

  logic [PAIR_W-1:0] acc;
  logic [CNT_W-1:0]  cnt, idx;
  logic              last;

  assign idx  = first ? '0 : cnt;
  assign last = (idx == (nib_mode ? LAST_NIB : LAST_BYTE));
  assign done = take && last;
  assign pair = nib_mode ? {acc[PAIR_W-NIB_W-1:0], lane[NIB_W-1:0]}
                         : {acc[PAIR_W-BUS_W-1:0], lane};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= pair;
      cnt <= last ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/iqwb_convert.sv
module iqwb_convert #(
  parameter int SAMPLE_W = 16
) (
  input  logic [2*SAMPLE_W-1:0] pair,
  input  logic                  q_first,
  input  logic                  offset_bin,
  output logic [SAMPLE_W-1:0]   smp_i,
  output logic [SAMPLE_W-1:0]   smp_q
);
  logic [SAMPLE_W-1:0] w0, w1, flip;

  assign w0    = pair[2*SAMPLE_W-1:SAMPLE_W];
  assign w1    = pair[SAMPLE_W-1:0];
  assign flip  = {offset_bin, {(SAMPLE_W-1){1'b0}}};
  assign smp_i = (q_first ? w1 : w0) ^ flip;
  assign smp_q = (q_first ? w0 : w1) ^ flip;
endmodule

// File: rtl/iq_word_builder.sv
module iq_word_builder #(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8,
  parameter int NIB_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_q_first,
  input  logic                cfg_bitrev,
  input  logic                cfg_offset_bin,
  output logic                cfg_err,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BUS_W-1:0]    in_data,
  input  logic                in_first,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);
  import iqwb_pkg::*;

  width_mode_e           mode;
  logic                  nib_mode, take, done;
  logic [BUS_W-1:0]      lane;
  logic [2*SAMPLE_W-1:0] pair;
  logic [SAMPLE_W-1:0]   nxt_i, nxt_q;

  assign mode     = decode_width(cfg_width);
  assign nib_mode = (mode == WM_NIBBLE);
  assign cfg_err  = (mode == WM_BAD);
  assign in_ready = cfg_err || !out_valid || out_ready;
  assign take     = in_valid && in_ready && !cfg_err;

  iqwb_lane #(.BUS_W(BUS_W), .NIB_W(NIB_W)) u_lane (
    .raw(in_data), .nib_mode(nib_mode), .bitrev(cfg_bitrev), .lane(lane)
  );

  iqwb_assembler #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W), .NIB_W(NIB_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .take(take), .first(in_first),
    .nib_mode(nib_mode), .lane(lane), .done(done), .pair(pair)
  );

  iqwb_convert #(.SAMPLE_W(SAMPLE_W)) u_conv (
    .pair(pair), .q_first(cfg_q_first), .offset_bin(cfg_offset_bin),
    .smp_i(nxt_i), .smp_q(nxt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_i     <= nxt_i;
      out_q     <= nxt_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iqwb_checker.sv
module iqwb_checker #(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_width,
  input logic                cfg_err,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_first,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_i,
  input logic [SAMPLE_W-1:0] out_q
);
  // R9: a blocked pair is held unchanged
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  // R9: no beat is accepted while a valid-mode pair is blocked
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cfg_width != 2'b11) |-> !in_ready);

  // R8: invalid code flags the error and sinks beats
  a_r8_err_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'b11) |-> (cfg_err && in_ready));

  // R8: no new pair appears in invalid mode
  a_r8_no_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'b11 && !out_valid) |=> !out_valid);

  // R10: a pair only follows an accepted beat
  a_r10_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind iq_word_builder iqwb_checker #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_iq_word_builder.sv
`timescale 1ns/1ps
module tb_iq_word_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b00;
  logic        cfg_q_first = 1'b0, cfg_bitrev = 1'b0, cfg_offset_bin = 1'b0;
  logic        cfg_err, in_ready, out_valid;
  logic        in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_data = '0;
  logic [15:0] out_i, out_q;

  int checks = 0, fails = 0;
  logic [15:0] exp_i[$], exp_q[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  iq_word_builder dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] v, input int w);
    logic [7:0] r = '0;
    for (int k = 0; k < w; k++) r[k] = v[w-1-k];
    return r;
  endfunction

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_i.size() == 0) begin
        check(0, "R8/R10 unexpected pair", {out_i, out_q}, 32'h0);
      end else begin
        automatic logic [15:0] ei = exp_i.pop_front();
        automatic logic [15:0] eq = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        check({out_i, out_q} == {ei, eq}, t, {out_i, out_q}, {ei, eq});
      end
    end
  end

  task automatic beat(input logic [7:0] d, input bit first);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = first;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  // driver: send words a then b in arrival order; nbeats < full truncates
  task automatic send(input logic [15:0] a, input logic [15:0] b, input string tag, input int limit = 99);
    automatic logic [31:0] p = {a, b};
    automatic bit nib = (cfg_width == 2'b10);
    automatic int w = nib ? 4 : 8;
    automatic int n = 32 / w;
    automatic logic [15:0] f = cfg_offset_bin ? 16'h8000 : 16'h0;
    if (limit >= n) begin
      exp_i.push_back((cfg_q_first ? b : a) ^ f);
      exp_q.push_back((cfg_q_first ? a : b) ^ f);
      exp_tag.push_back(tag);
    end
    for (int k = 0; k < n && k < limit; k++) begin
      automatic logic [7:0] ch = 8'((p >> (32 - w*(k+1))) & ((32'h1 << w) - 1));
      if (cfg_bitrev) ch = mirror(ch, w);
      if (nib) ch = ch | 8'hA0;  // R3: upper pins carry junk
      beat(ch, k == 0);
    end
  endtask

  task automatic drain();
    while (exp_i.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 32'h0, 32'h1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
    check(cfg_err == 1'b0, "R1 cfg_err", 32'(cfg_err), 32'h0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);

    // R2 byte mode, both codes; R10 timing is asserted in the checker
    send(16'h1234, 16'hABCD, "R2 byte code00");
    cfg_width = 2'b01;
    send(16'h8001, 16'h7FFE, "R2 byte code01");
    // R4 Q first
    cfg_q_first = 1'b1;
    send(16'h5A5A, 16'hC3C3, "R4 q_first byte");
    cfg_q_first = 1'b0;
    // R5 reversal, byte
    drain(); cfg_bitrev = 1'b1;
    send(16'h0F01, 16'h8040, "R5 bitrev byte");
    // R6 offset binary
    drain(); cfg_bitrev = 1'b0; cfg_offset_bin = 1'b1;
    send(16'h8000, 16'h0000, "R6 offset byte");
    drain(); cfg_offset_bin = 1'b0;
    send(16'h8000, 16'h0000, "R6 twos passthrough");
    // R3 nibble mode
    drain(); cfg_width = 2'b10;
    send(16'h1357, 16'h9BDF, "R3 nibble");
    cfg_bitrev = 1'b1;
    send(16'h1248, 16'hE731, "R5 bitrev nibble");
    cfg_bitrev = 1'b0; cfg_q_first = 1'b1; cfg_offset_bin = 1'b1;
    send(16'h0123, 16'hFEDC, "R4 R6 nibble combo");
    cfg_q_first = 1'b0; cfg_offset_bin = 1'b0;
    // R7 realign after partial pair, nibble then byte
    send(16'hFFFF, 16'hFFFF, "R7 partial", 3);
    send(16'h2468, 16'h1357, "R7 realign nibble");
    drain(); cfg_width = 2'b00;
    send(16'hEEEE, 16'hEEEE, "R7 partial", 3);
    send(16'h0001, 16'h0002, "R7 realign byte");

    // R9 back-pressure
    drain();
    out_ready = 1'b0;
    send(16'hCAFE, 16'hBEEF, "R9 released pair");
    repeat (3) begin
      @(negedge clk); #1;
      check(out_valid == 1'b1, "R9 held valid", 32'(out_valid), 32'h1);
      check({out_i, out_q} == 32'hCAFEBEEF, "R9 held data", {out_i, out_q}, 32'hCAFEBEEF);
      check(in_ready == 1'b0, "R9 in_ready low", 32'(in_ready), 32'h0);
    end
    @(negedge clk); out_ready = 1'b1;
    drain();

    // R8 invalid code
    cfg_width = 2'b11;
    @(negedge clk); #1;
    check(cfg_err == 1'b1, "R8 cfg_err", 32'(cfg_err), 32'h1);
    check(in_ready == 1'b1, "R8 in_ready", 32'(in_ready), 32'h1);
    for (int k = 0; k < 8; k++) beat(8'h3C, k == 0);
    repeat (2) @(negedge clk); #1;
    check(out_valid == 1'b0, "R8 no pair", 32'(out_valid), 32'h0);
    cfg_width = 2'b00;
    @(negedge clk); #1;
    check(cfg_err == 1'b0, "R8 err clears", 32'(cfg_err), 32'h0);
    send(16'h4321, 16'h8765, "R8 recovery byte");
    drain();
    check(exp_i.size() == 0, "R2 scoreboard empty", 32'(exp_i.size()), 32'h0);
    report();
  end
endmodule